// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit with Sign/Zero Flags

This block computes the low word of `op_a * op_b + op_c` on a shift-and-add datapath. It retires one multiplier digit of `DIGIT_W` bits per clock. A pulse on `start` captures all operands. The unit then walks through `op_b` from its least significant digit upward. It stops on the first cycle in which no set bit remains above the digit just consumed. A short multiplier therefore finishes in fewer cycles than a full-width one.

When `acc_en` is low the addend is forced to zero, and the block acts as a plain truncating multiplier. When `flags_en` is high at the start, the completing cycle also updates a negative flag and a zero flag taken from the result. When `flags_en` is low, both flags keep the values they had. A carry or overflow indication is never produced and never disturbed.

`done` marks the single cycle in which a new result is first presented. The result stays on `result` until the next operation completes. While an operation is in flight, further `start` pulses are dropped.

Top module: `mac_flag_unit`

## Requirements
- R1: On completion, `result` equals `(op_a * op_b + op_c) mod 2^DATA_W`, using the operands captured when `start` was accepted and with `acc_en` high.
- R2: With `acc_en` low at the accepted start, `op_c` has no effect and `result` equals `(op_a * op_b) mod 2^DATA_W`.
- R3: `done` rises exactly k clock edges after the edge that accepts `start`. Here k is the number of `DIGIT_W`-bit digits of `op_b` up to and including its highest non-zero digit, with k = 1 when `op_b` is zero, so k never exceeds `DATA_W/DIGIT_W`.
- R4: `done` is high for exactly one cycle per operation, and `result` does not change in any cycle where `done` is low.
- R5: If `flags_en` was high at the accepted start, then in the `done` cycle `flag_valid` is high, `n_flag` equals `result[DATA_W-1]` and `z_flag` is 1 exactly when `result` is zero.
- R6: If `flags_en` was low at the accepted start, `flag_valid` stays low and `n_flag`/`z_flag` keep their previous values. More generally, the flags change only in a cycle where `flag_valid` is high.
- R7: A `start` pulse arriving while an operation is in progress is ignored. The running operation completes with its own operands and its own latency.
- R8: After synchronous active-low reset, `result` is zero and `done`, `flag_valid`, `n_flag` and `z_flag` are all low.
- R9: Operands given as two's-complement negative values produce the same `result` as the signed product plus addend, truncated to `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Captures operands and begins an operation when idle |
| op_a | input | DATA_W | Multiplicand |
| op_b | input | DATA_W | Multiplier; its magnitude sets the latency |
| op_c | input | DATA_W | Addend |
| acc_en | input | 1 | Adds `op_c` when high, zero addend when low |
| flags_en | input | 1 | Requests update of the N and Z flags |
| result | output | DATA_W | Low word of product plus addend, held until the next completion |
| n_flag | output | 1 | Negative flag (result sign bit) |
| z_flag | output | 1 | Zero flag |
| flag_valid | output | 1 | High in the `done` cycle of an operation that updated the flags |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies of the block. The first uses `DATA_W=8, DIGIT_W=2`, which gives four digits. At that size every multiplier value can be swept against sixteen multiplicands spread across the full range, with the addend, accumulate enable and flag enable varying from case to case. This sweep covers every termination point and every flag outcome, and the expected result, latency and flag state are recomputed arithmetically. The second copy keeps the default `32/8` width. It carries directed corner cases (all-ones operands, wrap to zero, negative operands, one operand per latency step), a random batch, the dropped-start case and the flag-hold case.

// File: rtl/mac_pkg.sv
// Package: shared types for the multiply-accumulate unit.
// Assumes: nothing beyond IEEE 1800-2017.
package mac_pkg;

    // Sequencer states: waiting for work, or stepping through digits.
    typedef enum logic {
        MAC_IDLE = 1'b0,
        MAC_RUN  = 1'b1
    } mac_state_t;

endpackage

// File: rtl/mac_ctrl.sv
// Module: mac_ctrl
// Sequences one operation: accepts a start only when idle, steps once
// per cycle while running, and returns to idle on the final digit.
// Assumes: 'last' is valid combinationally whenever the unit is running.
module mac_ctrl
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    output logic load,
    output logic step,
    output logic finish
);

    mac_state_t state_q;
    mac_state_t state_d;

    // Decode the handshake strobes from the current state.
    always_comb begin
        load   = (state_q == MAC_IDLE) && start;
        step   = (state_q == MAC_RUN);
        finish = step && last;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            MAC_IDLE: if (start) state_d = MAC_RUN;
            MAC_RUN:  if (last)  state_d = MAC_IDLE;
            default:             state_d = MAC_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MAC_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/mac_digit_step.sv
// Module: mac_digit_step
// Combinational shift-and-add step: adds the multiplicand times the low
// multiplier digit into the accumulator, then advances both operands by one
// digit. 'last' flags that no set bit remains in the advanced multiplier.
// Assumes: DIGIT_W divides DATA_W and is smaller than it.
module mac_digit_step #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8
) (
    input  logic [DATA_W-1:0] mcand,
    input  logic [DATA_W-1:0] mplier,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] acc_nxt,
    output logic [DATA_W-1:0] mcand_nxt,
    output logic [DATA_W-1:0] mplier_nxt,
    output logic              last
);

    logic [DATA_W-1:0] term [DIGIT_W];

    // One gated, shifted copy of the multiplicand per digit bit.
    genvar gi;
    generate
        for (gi = 0; gi < DIGIT_W; gi++) begin : g_term
            assign term[gi] = mplier[gi] ? (mcand << gi) : '0;
        end
    endgenerate

    // Sum the partial terms into the running accumulator (wraps modulo 2^DATA_W).
    always_comb begin
        logic [DATA_W-1:0] sum;
        sum = acc;
        for (int j = 0; j < DIGIT_W; j++) begin
            sum = sum + term[j];
        end
        acc_nxt = sum;
    end

    // Advance operands by one digit and detect early termination.
    always_comb begin
        mcand_nxt  = mcand << DIGIT_W;
        mplier_nxt = mplier >> DIGIT_W;
        last       = (mplier_nxt == '0);
    end

endmodule

// File: rtl/mac_flag_reg.sv
// Module: mac_flag_reg
// Holds the negative and zero flags. They load from the completing value
// only when an update is requested; otherwise they keep their state.
// Assumes: 'upd' is high for at most one cycle per operation.
module mac_flag_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [DATA_W-1:0] value,
    output logic              n_q,
    output logic              z_q,
    output logic              valid_q
);

    // Flag storage: load on update, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q     <= 1'b0;
            z_q     <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= upd;
            if (upd) begin
                n_q <= value[DATA_W-1];
                z_q <= (value == '0);
            end
        end
    end

endmodule

// File: rtl/mac_flag_unit.sv
// Module: mac_flag_unit (top)
// Iterative multiply-accumulate: result = low DATA_W bits of a*b + c, one
// DIGIT_W-bit multiplier digit per cycle, with unsigned early termination
// on the multiplier operand. Optional negative/zero flag update.
// Assumes: DIGIT_W divides DATA_W and DIGIT_W < DATA_W.
module mac_flag_unit #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic              acc_en,
    input  logic              flags_en,
    output logic [DATA_W-1:0] result,
    output logic              n_flag,
    output logic              z_flag,
    output logic              flag_valid,
    output logic              done
);

    localparam int NUM_DIGITS = DATA_W / DIGIT_W;

    logic              load, step, finish, last;
    logic [DATA_W-1:0] mcand_q, mplier_q, acc_q;
    logic [DATA_W-1:0] acc_nxt, mcand_nxt, mplier_nxt;
    logic              setfl_q;
    logic [DATA_W-1:0] result_q;
    logic              done_q;

    mac_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .last   (last),
        .load   (load),
        .step   (step),
        .finish (finish)
    );

    mac_digit_step #(
        .DATA_W  (DATA_W),
        .DIGIT_W (DIGIT_W)
    ) u_step (
        .mcand      (mcand_q),
        .mplier     (mplier_q),
        .acc        (acc_q),
        .acc_nxt    (acc_nxt),
        .mcand_nxt  (mcand_nxt),
        .mplier_nxt (mplier_nxt),
        .last       (last)
    );

    mac_flag_reg #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (finish && setfl_q),
        .value   (acc_nxt),
        .n_q     (n_flag),
        .z_q     (z_flag),
        .valid_q (flag_valid)
    );

    // Operand capture on accept and digit advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            setfl_q  <= 1'b0;
        end else if (load) begin
            mcand_q  <= op_a;
            mplier_q <= op_b;
            acc_q    <= acc_en ? op_c : '0;
            setfl_q  <= flags_en;
        end else if (step) begin
            mcand_q  <= mcand_nxt;
            mplier_q <= mplier_nxt;
            acc_q    <= acc_nxt;
        end
    end

    // Result hold register and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) result_q <= acc_nxt;
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // Guard against configurations the datapath cannot represent.
    generate
        if (NUM_DIGITS * DIGIT_W != DATA_W || NUM_DIGITS < 2) begin : g_bad_cfg
            initial $error("mac_flag_unit: DIGIT_W must divide DATA_W and be smaller");
        end
    endgenerate

endmodule

// File: rtl/mac_flag_unit_chk.sv
// Module: mac_flag_unit_chk
// Property checker for mac_flag_unit, attached by bind. Tracks its own view
// of an operation in flight from start/done to bound the latency.
// Assumes: reset is asserted during the first clock cycles of simulation.
module mac_flag_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] result,
    input logic              n_flag,
    input logic              z_flag,
    input logic              flag_valid,
    input logic              done
);

    localparam int NUM_DIGITS = DATA_W / DIGIT_W;
    localparam int CNT_W      = $clog2(NUM_DIGITS + 3) + 1;

    logic             past_ok = 1'b0;
    logic             inflight_q;
    logic [CNT_W-1:0] age_q;

    // Marks that one clock edge has passed, so $past has history.
    always_ff @(posedge clk) past_ok <= 1'b1;

    // Shadow of an accepted operation and its age in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
            age_q      <= '0;
        end else if (inflight_q && done) begin
            inflight_q <= start;
            age_q      <= start ? CNT_W'(1) : '0;
        end else if (!inflight_q && start) begin
            inflight_q <= 1'b1;
            age_q      <= CNT_W'(1);
        end else if (inflight_q) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R3
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> (age_q <= CNT_W'(NUM_DIGITS + 1)));

    // R3
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> inflight_q);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !done |-> $stable(result));

    // R5
    flag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |-> done);

    // R5
    flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |-> (n_flag == result[DATA_W-1]) && (z_flag == (result == '0)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !flag_valid |-> ($stable(n_flag) && $stable(z_flag)));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(!rst_n) |-> (!done && !flag_valid && !n_flag && !z_flag && result == '0));

endmodule

bind mac_flag_unit mac_flag_unit_chk #(
    .DATA_W  (DATA_W),
    .DIGIT_W (DIGIT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .result     (result),
    .n_flag     (n_flag),
    .z_flag     (z_flag),
    .flag_valid (flag_valid),
    .done       (done)
);

// File: tb/mac_flag_unit_test.sv
// Bench for mac_flag_unit: a narrow 8-bit/2-bit copy swept nearly
// exhaustively, plus a default-width copy with directed and random cases.
module mac_flag_unit_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;

    always #2.5 clk = ~clk;

    // Narrow copy signals.
    logic       n_start = 1'b0, n_ae = 1'b0, n_fe = 1'b0;
    logic [7:0] n_a = '0, n_b = '0, n_c = '0;
    logic [7:0] n_res;
    logic       n_nf, n_zf, n_fv, n_done;

    // Wide copy signals.
    logic        w_start = 1'b0, w_ae = 1'b0, w_fe = 1'b0;
    logic [31:0] w_a = '0, w_b = '0, w_c = '0;
    logic [31:0] w_res;
    logic        w_nf, w_zf, w_fv, w_done;

    mac_flag_unit #(.DATA_W(8), .DIGIT_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .start(n_start), .op_a(n_a), .op_b(n_b),
        .op_c(n_c), .acc_en(n_ae), .flags_en(n_fe), .result(n_res),
        .n_flag(n_nf), .z_flag(n_zf), .flag_valid(n_fv), .done(n_done)
    );

    mac_flag_unit #(.DATA_W(32), .DIGIT_W(8)) uut_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .op_a(w_a), .op_b(w_b),
        .op_c(w_c), .acc_en(w_ae), .flags_en(w_fe), .result(w_res),
        .n_flag(w_nf), .z_flag(w_zf), .flag_valid(w_fv), .done(w_done)
    );

    // Model flag state for each copy.
    logic mn_n = 1'b0, mn_z = 1'b0, mw_n = 1'b0, mw_z = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [31:0] b, input int dw, input int nd);
        int k = 1;
        while (k < nd && (b >> (dw * k)) != 0) k++;
        return k;
    endfunction

    // One operation on the narrow copy with all checks.
    task automatic n_op(input logic [7:0] a, b, c, input logic ae, fe);
        int lat = 0;
        logic [7:0] exp;
        exp = 8'(int'(a) * int'(b) + (ae ? int'(c) : 0));
        @(negedge clk);
        n_a = a; n_b = b; n_c = c; n_ae = ae; n_fe = fe; n_start = 1'b1;
        @(negedge clk);
        n_start = 1'b0;
        while (!n_done && lat < 20) begin @(negedge clk); lat++; end
        chk(lat == lat_of(32'(b), 2, 4), "R3 narrow latency", 64'(lat), 64'(lat_of(32'(b), 2, 4)));
        chk(n_res == exp, ae ? "R1 narrow result" : "R2 narrow no-accumulate", 64'(n_res), 64'(exp));
        if (fe) begin
            mn_n = exp[7];
            mn_z = (exp == 0);
        end
        chk(n_fv == fe, fe ? "R5 narrow flag_valid" : "R6 narrow flag_valid", 64'(n_fv), 64'(fe));
        chk({n_nf, n_zf} == {mn_n, mn_z}, fe ? "R5 narrow flags" : "R6 narrow flags held",
            64'({n_nf, n_zf}), 64'({mn_n, mn_z}));
        @(negedge clk);
        chk(!n_done && n_res == exp, "R4 narrow pulse and hold", 64'({n_done, n_res}), 64'(exp));
    endtask

    // One operation on the wide copy; returns measured latency.
    task automatic w_op(input logic [31:0] a, b, c, input logic ae, fe, input string tag);
        int lat = 0;
        logic [63:0] p;
        logic [31:0] exp;
        p   = {32'b0, a} * {32'b0, b};
        exp = p[31:0] + (ae ? c : 32'b0);
        @(negedge clk);
        w_a = a; w_b = b; w_c = c; w_ae = ae; w_fe = fe; w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        while (!w_done && lat < 20) begin @(negedge clk); lat++; end
        chk(lat == lat_of(b, 8, 4), "R3 wide latency", 64'(lat), 64'(lat_of(b, 8, 4)));
        chk(w_res == exp, tag, 64'(w_res), 64'(exp));
        if (fe) begin
            mw_n = exp[31];
            mw_z = (exp == 0);
        end
        chk(w_fv == fe && {w_nf, w_zf} == {mw_n, mw_z}, fe ? "R5 wide flags" : "R6 wide flags held",
            64'({w_fv, w_nf, w_zf}), 64'({fe, mw_n, mw_z}));
        @(negedge clk);
        chk(!w_done, "R4 wide done pulse", 64'(w_done), 64'(0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state on both copies
        chk(n_res == 0 && !n_done && !n_fv && !n_nf && !n_zf, "R8 narrow reset", 64'({n_res, n_done, n_fv, n_nf, n_zf}), 64'(0));
        chk(w_res == 0 && !w_done && !w_fv && !w_nf && !w_zf, "R8 wide reset", 64'({w_res, w_done, w_fv, w_nf, w_zf}), 64'(0));

        // Narrow sweep: every multiplier against sixteen multiplicands.
        for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                n_op(8'(ai * 17), 8'(bi), 8'(ai * 7 + bi * 13), bi[1], bi[0] ^ ai[0]);
            end
        end

        // Wide directed corners (R1, R2, R5, R9).
        w_op(32'h0, 32'h0, 32'h0, 1'b1, 1'b1, "R1 zero");
        w_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, "R1 all ones");
        w_op(32'hFFFF_FFFF, 32'h1, 32'h1, 1'b1, 1'b1, "R1 wrap to zero");
        w_op(32'h8000_0000, 32'h2, 32'h0, 1'b1, 1'b1, "R1 high bit out");
        w_op(32'h1234_5678, 32'h0000_0100, 32'h5, 1'b1, 1'b0, "R1 two digits");
        w_op(32'h1234_5678, 32'h0001_0000, 32'hDEAD, 1'b0, 1'b1, "R2 three digits");
        w_op(32'h0000_0003, 32'h0100_0000, 32'h7, 1'b1, 1'b1, "R1 four digits");
        // R9: -3 * 7 + -1 truncated equals signed arithmetic
        w_op(32'hFFFF_FFFD, 32'h7, 32'hFFFF_FFFF, 1'b1, 1'b1, "R9 signed operands");
        chk(w_res == 32'(-22), "R9 signed value", 64'(w_res), 64'(32'(-22)));
        w_op(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 1'b1, 1'b0, "R9 negative squared");
        chk(w_res == 32'd256, "R9 negative squared value", 64'(w_res), 64'(256));

        // Wide random batch with varied multiplier length.
        for (int i = 0; i < 200; i++) begin
            logic [31:0] rb;
            rb = $urandom;
            rb = rb >> (8 * (i % 4));
            w_op($urandom, rb, $urandom, i[0], i[1], i[0] ? "R1 random" : "R2 random");
        end

        // R6: negative result with flags, then zero result without flags.
        w_op(32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, 1'b1, "R5 set negative");
        chk(w_nf && !w_zf, "R5 negative flag", 64'({w_nf, w_zf}), 64'(2));
        w_op(32'h0, 32'h5, 32'h0, 1'b0, 1'b0, "R6 zero without flags");
        chk(w_nf && !w_zf && !w_fv, "R6 flags untouched", 64'({w_nf, w_zf, w_fv}), 64'(4));

        // R7: extra start while busy is dropped.
        begin
            int lat = 0;
            @(negedge clk);
            w_a = 32'h3; w_b = 32'hFF00_0000; w_c = 32'h1; w_ae = 1'b1; w_fe = 1'b0; w_start = 1'b1;
            @(negedge clk);
            w_a = 32'h9; w_b = 32'h1; w_c = 32'h0;
            @(negedge clk);
            lat = 1;
            w_start = 1'b0;
            while (!w_done && lat < 20) begin @(negedge clk); lat++; end
            chk(lat == 4, "R7 latency of first op", 64'(lat), 64'(4));
            chk(w_res == 32'hFD00_0001, "R7 first op result kept", 64'(w_res), 64'(32'hFD00_0001));
            @(negedge clk);
            @(negedge clk);
            chk(!w_done && w_res == 32'hFD00_0001, "R7 no second completion", 64'({w_done, w_res}), 64'(32'hFD00_0001));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule